// File: doc/BRIEF.md
# Packet Header Deframer with Length Check

This block sits on a 64-bit streaming path that uses valid/ready/last handshaking. A beat moves only on a clock edge where valid and ready are both high. The first beat of each packet is a header word. The block splits that word into four fields: flags, a sequence number, a total byte count and a stream identifier. One flag says that a 64-bit timestamp follows. When it is set, the block takes the second beat as that timestamp.

The remaining beats are payload. They pass straight through to the output, and the header fields and timestamp are held on sideband outputs for the whole packet. A separate output gives the number of valid bytes in the final payload word, so downstream logic can mask it.

The block does not trust the framing alone. It counts every accepted beat, including the header and time beats, against the beat count implied by the byte count. It raises a sticky error when the last beat lands anywhere else.

Top module: `pkt_deframer`

## Requirements
- R1: On an accepted header beat the block splits the word into fields. Bits [63:60] go to `flags_o` (bit 63 extension context, bit 62 trailer present, bit 61 time word follows, bit 60 end of burst). Bits [59:48] go to `seq_o`, bits [47:32] to `size_o` (bytes in the whole packet) and bits [31:0] to `sid_o`.
- R2: When header bit 61 is set and the header beat is not last, the next accepted beat is stored in `time_o`. `time_valid_o` always shows bit 61 of the most recently accepted header.
- R3: Every beat accepted after the header, and after the timestamp when present, appears on `out_data_o`/`out_last_o` unchanged, with `out_valid_o` high, in the same cycle.
- R4: Header and timestamp beats never appear on the output. While one is expected, `in_ready_o` is high whatever the value of `out_ready_i`.
- R5: While payload is expected, `in_ready_o` follows `out_ready_i`, so a stalled output holds the input beat.
- R6: The sideband outputs (`flags_o`, `seq_o`, `size_o`, `sid_o`, `time_valid_o`, `last_bytes_o`) change only when a header beat is accepted. `time_o` changes only when a timestamp beat is accepted. Input data without a handshake has no effect on them.
- R7: The header counts as beat 1. If the last beat is accepted as beat number n, and n differs from ceil(`size_o`/8), `len_err_o` is set.
- R8: `len_err_o` stays set until the next header beat is accepted. It is cleared then, unless that header beat is itself a last beat that fails the R7 check.
- R9: `last_bytes_o` equals the byte count modulo 8, and is 8 when that remainder is 0.
- R10: A packet whose byte count gives one beat (or two beats with the time flag) must end on its header beat (or its timestamp beat). It then sends nothing to the output. Ending a time-flagged packet on its header is an R7 error when its count gives two beats.
- R11: Asserting `rst_ni` low returns the block to expecting a header and clears `len_err_o`, all fields and the timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| in_data_i | input | 64 | Input beat |
| in_last_i | input | 1 | Final beat of the packet |
| out_valid_o | output | 1 | Payload beat valid |
| out_ready_i | input | 1 | Downstream can take a payload beat |
| out_data_o | output | 64 | Payload beat |
| out_last_o | output | 1 | Final payload beat |
| flags_o | output | 4 | Header flags |
| seq_o | output | 12 | Sequence number |
| size_o | output | 16 | Packet size in bytes |
| sid_o | output | 32 | Stream identifier |
| time_valid_o | output | 1 | Header says a timestamp follows |
| time_o | output | 64 | Captured timestamp |
| last_bytes_o | output | 4 | Valid bytes in the final beat, 1 to 8 |
| len_err_o | output | 1 | Sticky length mismatch |

## Verification
A wrong phase register shows up on the first beat after it goes wrong. A header or timestamp word leaks to the output, a payload word gets taken as a header, or `in_ready_o` ignores `out_ready_i`. The bench sees this on that same beat, because the output path has no register in it. A wrong beat counter or size register only shows up when the last beat arrives: `len_err_o` is wrong one cycle after that beat. That is why the packets in the bench end early, on time, late, on the header beat and on the timestamp beat. Corrupted field registers show up at the end-of-packet comparison, and again after idle cycles with garbage data on the input.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;
  localparam int FLAG_W = 4;
  localparam int SEQ_W  = 12;
  localparam int SIZE_W = 16;
  localparam int SID_W  = 32;
  localparam int WORD_W = FLAG_W + SEQ_W + SIZE_W + SID_W;
  localparam int BEAT_BYTES = WORD_W / 8;
  localparam int LANE_W = $clog2(BEAT_BYTES);
  localparam int CNT_W  = SIZE_W - LANE_W + 1;
  localparam int FLAG_TIME = 1;  // index inside the flag field (word bit 61)

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [SEQ_W-1:0]  seq;
    logic [SIZE_W-1:0] size;
    logic [SID_W-1:0]  sid;
  } hdr_t;

  typedef enum logic [1:0] {PH_HDR, PH_TIME, PH_PAY} phase_e;
endpackage

// File: rtl/pkt_phase_fsm.sv
module pkt_phase_fsm
  import pkt_deframer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fire_i,
  input  logic   last_i,
  input  logic   time_flag_i,
  output phase_e phase_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_HDR;
    else if (fire_i) begin
      unique case (phase_q)
        PH_HDR:  if (!last_i) phase_q <= time_flag_i ? PH_TIME : PH_PAY;
        PH_TIME: phase_q <= last_i ? PH_HDR : PH_PAY;
        PH_PAY:  if (last_i) phase_q <= PH_HDR;
        default: phase_q <= PH_HDR;
      endcase
    end
  end

  assign phase_o = phase_q;

  // R7
  last_to_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && last_i) |=> (phase_q == PH_HDR));
endmodule

// File: rtl/pkt_hdr_capture.sv
module pkt_hdr_capture
  import pkt_deframer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_acc_i,
  input  logic              time_acc_i,
  input  logic [WORD_W-1:0] data_i,
  output hdr_t              hdr_o,
  output logic [WORD_W-1:0] time_o
);
  hdr_t              hdr_q;
  logic [WORD_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q  <= '0;
      time_q <= '0;
    end else begin
      if (hdr_acc_i)  hdr_q  <= hdr_t'(data_i);
      if (time_acc_i) time_q <= data_i;
    end
  end

  assign hdr_o  = hdr_q;
  assign time_o = time_q;

  // R6
  hdr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_acc_i |=> $stable(hdr_q));
  // R6
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_acc_i |=> $stable(time_q));
endmodule

// File: rtl/pkt_len_check.sv
module pkt_len_check
  import pkt_deframer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              last_i,
  input  logic              hdr_acc_i,
  input  logic [SIZE_W-1:0] size_in_i,
  input  logic [SIZE_W-1:0] size_q_i,
  output logic              len_err_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [SIZE_W:0]   sum_in, sum_q;
  logic [CNT_W-1:0]  exp_in, exp_q;
  logic              err_q;

  // ceil(size / BEAT_BYTES)
  assign sum_in  = {1'b0, size_in_i} + (SIZE_W+1)'(BEAT_BYTES - 1);
  assign sum_q   = {1'b0, size_q_i}  + (SIZE_W+1)'(BEAT_BYTES - 1);
  assign exp_in  = CNT_W'(sum_in >> LANE_W);
  assign exp_q   = CNT_W'(sum_q  >> LANE_W);
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (hdr_acc_i) begin
      cnt_q <= CNT_W'(1);
      err_q <= last_i && (exp_in != CNT_W'(1));
    end else if (fire_i) begin
      cnt_q <= cnt_nxt;
      if (last_i && (cnt_nxt != exp_q)) err_q <= 1'b1;
    end
  end

  assign len_err_o = err_q;

  // R8
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_acc_i && !last_i) |=> !len_err_o);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_err_o && !hdr_acc_i) |=> len_err_o);
endmodule

// File: rtl/pkt_payload_gate.sv
module pkt_payload_gate
  import pkt_deframer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_last_o
);
  logic pay;

  assign pay         = (phase_i == PH_PAY);
  assign out_valid_o = in_valid_i && pay;
  assign in_ready_o  = pay ? out_ready_i : 1'b1;
  assign out_data_o  = in_data_i;
  assign out_last_o  = in_last_i;

  // R4
  hdr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_PAY) |-> (in_ready_o && !out_valid_o));
  // R5
  backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay && !out_ready_i) |-> !in_ready_o);
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_deframer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [SID_W-1:0]  sid_o,
  output logic              time_valid_o,
  output logic [WORD_W-1:0] time_o,
  output logic [LANE_W:0]   last_bytes_o,
  output logic              len_err_o
);
  phase_e phase;
  hdr_t   in_hdr, hdr_q;
  logic   fire, hdr_acc, time_acc;

  assign in_hdr   = hdr_t'(in_data_i);
  assign fire     = in_valid_i && in_ready_o;
  assign hdr_acc  = fire && (phase == PH_HDR);
  assign time_acc = fire && (phase == PH_TIME);

  pkt_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .last_i      (in_last_i),
    .time_flag_i (in_hdr.flags[FLAG_TIME]),
    .phase_o     (phase)
  );

  pkt_hdr_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hdr_acc_i  (hdr_acc),
    .time_acc_i (time_acc),
    .data_i     (in_data_i),
    .hdr_o      (hdr_q),
    .time_o     (time_o)
  );

  pkt_len_check u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .last_i    (in_last_i),
    .hdr_acc_i (hdr_acc),
    .size_in_i (in_hdr.size),
    .size_q_i  (hdr_q.size),
    .len_err_o (len_err_o)
  );

  pkt_payload_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o)
  );

  assign flags_o      = hdr_q.flags;
  assign seq_o        = hdr_q.seq;
  assign size_o       = hdr_q.size;
  assign sid_o        = hdr_q.sid;
  assign time_valid_o = hdr_q.flags[FLAG_TIME];
  assign last_bytes_o = (hdr_q.size[LANE_W-1:0] == '0) ? (LANE_W+1)'(BEAT_BYTES)
                                                      : {1'b0, hdr_q.size[LANE_W-1:0]};

  // R9
  last_bytes_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_bytes_o != '0) && (last_bytes_o <= (LANE_W+1)'(BEAT_BYTES)));
  // R3
  pay_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (in_valid_i && !hdr_acc && !time_acc));
endmodule

// File: tb/pkt_deframer_tb.sv
module pkt_deframer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [63:0] in_data = '0;
  logic        in_ready, out_valid, out_last, time_valid, len_err;
  logic [63:0] out_data, time_v;
  logic [3:0]  flags, last_bytes;
  logic [11:0] seq;
  logic [15:0] size;
  logic [31:0] sid;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int pay_seen, pay_bad;

  always #5 clk = ~clk;

  pkt_deframer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_last_i(in_last), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .flags_o(flags), .seq_o(seq), .size_o(size), .sid_o(sid),
    .time_valid_o(time_valid), .time_o(time_v), .last_bytes_o(last_bytes),
    .len_err_o(len_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stall: {stall, tflag, size[15:0], nbeats[7:0]}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'd40, 8'd5},
    {1'b1, 1'b1, 16'd37, 8'd5},
    {1'b0, 1'b0, 16'd20, 8'd2},
    {1'b0, 1'b0, 16'd20, 8'd4},
    {1'b0, 1'b0, 16'd8,  8'd1},
    {1'b1, 1'b1, 16'd16, 8'd2},
    {1'b1, 1'b0, 16'd17, 8'd3},
    {1'b0, 1'b1, 16'd16, 8'd1}
  };

  task automatic send_beat(input logic [63:0] d, input bit last, input bit is_pay, input bit stall);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    if (stall) begin
      out_ready = 1'b0;
      #1;
      if (is_pay) begin
        chk(!in_ready, "R5 stalled payload ready", 64'(in_ready), 64'd0);
        @(negedge clk);
        out_ready = 1'b1;
      end else begin
        chk(in_ready && !out_valid, "R4 header beat ready under stall", 64'(in_ready), 64'd1);
      end
    end else begin
      out_ready = 1'b1;
    end
    #1;
    if (is_pay) begin
      pay_seen++;
      if (!(out_valid && out_data == d && out_last == last)) pay_bad++;
    end else if (out_valid) pay_bad++;
    @(posedge clk);
    out_ready = 1'b1;
  endtask

  task automatic send_pkt(input int idx, input bit stall, input bit tflag,
                          input logic [15:0] sz, input int nbeats);
    logic [63:0] hdr, tm;
    logic [3:0] fl;
    int exp_pay, exp_beats;
    bit exp_err;
    logic [15:0] j;
    fl  = {idx[0], 1'b0, tflag, idx[1]};
    hdr = {fl, 12'(idx * 3 + 1), sz, 32'hA500_0000 + 32'(idx)};
    tm  = 64'h1000_0000_0000_0000 + 64'(idx) * 64'h0101;
    pay_seen = 0; pay_bad = 0;
    send_beat(hdr, nbeats == 1, 1'b0, stall);
    if (tflag && nbeats > 1) send_beat(tm, nbeats == 2, 1'b0, stall);
    exp_pay = (nbeats == 1) ? 0 : (tflag ? nbeats - 2 : nbeats - 1);
    j = 16'd0;
    for (int b = 0; b < exp_pay; b++) begin
      send_beat({j, j + 16'd1, j + 16'd2, j + 16'd3}, b == exp_pay - 1, 1'b1, stall);
      j = j + 16'd4;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #1;
    exp_beats = (int'(sz) + 7) / 8;
    exp_err = (nbeats != exp_beats);
    chk({flags, seq, size, sid} == hdr, "R1 header fields", {flags, seq, size, sid}, hdr);
    chk(time_valid == tflag, "R2 time_valid", 64'(time_valid), 64'(tflag));
    if (tflag && nbeats > 1) chk(time_v == tm, "R2 timestamp", time_v, tm);
    chk(pay_bad == 0 && pay_seen == exp_pay, "R3 R4 R10 payload beats",
        64'(pay_seen), 64'(exp_pay));
    chk(len_err == exp_err, "R7 R8 length error", 64'(len_err), 64'(exp_err));
    chk(last_bytes == ((sz % 8 == 0) ? 4'd8 : 4'(sz % 8)), "R9 last bytes",
        64'(last_bytes), 64'((sz % 8 == 0) ? 8 : sz % 8));
  endtask

  initial begin
    logic [63:0] snap;
    #1;
    chk(in_ready && !out_valid && !len_err && !time_valid && size == 0,
        "R11 reset state", {in_ready, out_valid, len_err, time_valid}, 64'b1000);
    chk(last_bytes == 4'd8, "R9 last bytes at size 0", 64'(last_bytes), 64'd8);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      send_pkt(i, VEC[i][25], VEC[i][24], VEC[i][23:8], int'(VEC[i][7:0]));

    // R8: sticky error held over idle cycles
    chk(len_err == 1'b1, "R8 error after last packet", 64'(len_err), 64'd1);
    // R6: no handshake, garbage on data
    snap = {flags, seq, size, sid};
    @(negedge clk);
    in_data = '1; in_last = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk({flags, seq, size, sid} == snap, "R6 fields held without handshake",
        {flags, seq, size, sid}, snap);
    chk(len_err == 1'b1, "R8 error held while idle", 64'(len_err), 64'd1);
    in_last = 1'b0;

    // R11: reset mid packet
    send_beat({4'b0010, 12'd9, 16'd40, 32'h1}, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(!len_err && !time_valid && size == 0 && time_v == 0, "R11 async reset clears",
        {len_err, time_valid, size}, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    send_pkt(9, 1'b0, 1'b0, 16'd24, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule